// File: doc/BRIEF.md
# Taint-Tracking Sequential Core Datapath

This block is a small in-order core datapath that carries a one-bit taint next to every data value. It takes one instruction per cycle: an add, a load, a store, or a branch-like operation that only reads operands. A load or store forms its address as `rs1 + imm`. A load whose address falls outside a configured window of valid addresses marks its result as tainted. Taint is carried through the adder. A result reaches the register file only after it has waited in an in-order result queue. An external retire pulse releases the head of that queue.

Every instruction carries a mispredict tag. A tagged instruction still executes and still reaches memory, but its result is discarded when it leaves the queue, so it writes neither a value nor a taint. Operands are forwarded from the youngest pending queue entry for the same register. A sticky violation flag rises when any memory access uses a tainted address, whether or not the access was tagged. Loaded data comes from an input port driven by the environment.

Top module: `taint_core`

## Requirements
- R1: After reset every register holds 0 and is untainted, `violation` is 0 and `instr_ready` is 1.
- R2: Op 2'b00 (add) writes `rs1 + rs2` modulo 2^DW to `rd`, with taint equal to the OR of the two operand taints. The data never depends on taint.
- R3: Op 2'b01 (load) writes `mem_rdata` to `rd`. The taint is set exactly when the address `rs1 + imm` is below WIN_LO (default 4) or above WIN_HI (default 23). The bounds themselves are clean.
- R4: When the queue holds DEPTH (default 4) pending results, `instr_ready` is 0 and a presented instruction is neither accepted nor sent to memory. Each retire pulse frees one slot.
- R5: A retire pulse while the queue is empty has no effect; the queue still accepts exactly DEPTH further results.
- R6: Operands come from the youngest queued, non-aborted result for that register, data and taint together, or else from the register file.
- R7: A result with `instr_mispred` set is never written, so the destination keeps its previous value and taint.
- R8: Op 2'b10 (store) drives `mem_we`=1, `mem_addr`=`rs1 + imm`, `mem_wdata`/`mem_wtaint` = the `rs2` value and taint. Stores and op 2'b11 (branch) write no register.
- R9: An accepted load or store whose `rs1` taint is set raises `violation` on the next cycle, even when mispredicted. It stays 1 until reset. Tainted operands of an add or branch never raise it.
- R10: `mem_req` is 1 in the cycle of an accepted load or store and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Instruction can be accepted (queue not full) |
| instr_op | input | 2 | 00 add, 01 load, 10 store, 11 branch |
| instr_rd | input | $clog2(NREG) | Destination register |
| instr_rs1 | input | $clog2(NREG) | First source / address base |
| instr_rs2 | input | $clog2(NREG) | Second source / store data |
| instr_imm | input | DW | Address offset |
| instr_mispred | input | 1 | Mispredict tag of this instruction |
| retire | input | 1 | Release one queued result to the register file |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | DW | Access address |
| mem_wdata | output | DW | Store data |
| mem_wtaint | output | 1 | Taint of the store data |
| mem_rdata | input | DW | Load data, same cycle |
| violation | output | 1 | Sticky tainted-address flag |

## Verification
The memory outputs are combinational from the presented instruction, so the bench samples them in the same cycle, two nanoseconds before the capturing edge. A result is pushed at the edge that accepts its instruction. Through forwarding, it is visible to the instruction presented in the very next cycle, so each store observing a register directly follows its producer or comes later. `violation` and `instr_ready` are registered or derived from registered state, so the bench reads them only in the cycle after the edge that caused the change. Register-file contents are observed only through later stores, after the queue has been drained by retire pulses.

// File: rtl/taint_pkg.sv
package taint_pkg;
  typedef enum logic [1:0] {
    OP_ADD    = 2'b00,
    OP_LOAD   = 2'b01,
    OP_STORE  = 2'b10,
    OP_BRANCH = 2'b11
  } op_e;
endpackage

// File: rtl/tc_exec.sv
module tc_exec
  import taint_pkg::*;
#(
  parameter int DW     = 5,
  parameter int WIN_LO = 4,
  parameter int WIN_HI = 23
) (
  input  op_e           op,
  input  logic [DW-1:0] a_val,
  input  logic          a_tnt,
  input  logic [DW-1:0] b_val,
  input  logic          b_tnt,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] res_val,
  output logic          res_tnt,
  output logic [DW-1:0] addr,
  output logic          addr_tnt,
  output logic          mem_acc,
  output logic          writes
);
  localparam logic [DW-1:0] LO = DW'(WIN_LO);
  localparam logic [DW-1:0] HI = DW'(WIN_HI);

  always_comb begin
    addr     = a_val + imm;
    addr_tnt = a_tnt;
    mem_acc  = (op == OP_LOAD) || (op == OP_STORE);
    writes   = (op == OP_LOAD) || (op == OP_ADD);
    if (op == OP_LOAD) begin
      res_val = rdata;
      res_tnt = (addr < LO) || (addr > HI);
    end else begin
      res_val = a_val + b_val;
      res_tnt = a_tnt | b_tnt;
    end
  end
endmodule

// File: rtl/tc_regfile.sv
module tc_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 5,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RIW-1:0] wa,
  input  logic [DW-1:0]  wd,
  input  logic           wt,
  input  logic [RIW-1:0] ra1,
  input  logic [RIW-1:0] ra2,
  output logic [DW-1:0]  rd1,
  output logic           rt1,
  output logic [DW-1:0]  rd2,
  output logic           rt2
);
  logic [DW-1:0] val_q [NREG];
  logic          tnt_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = we && (wa == RIW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[g] <= '0;
        tnt_q[g] <= 1'b0;
      end else if (hit) begin
        val_q[g] <= wd;
        tnt_q[g] <= wt;
      end
    end
  end

  assign rd1 = val_q[ra1];
  assign rt1 = tnt_q[ra1];
  assign rd2 = val_q[ra2];
  assign rt2 = tnt_q[ra2];
endmodule

// File: rtl/tc_resq.sv
module tc_resq #(
  parameter int NREG  = 8,
  parameter int DW    = 5,
  parameter int DEPTH = 4,
  localparam int RIW  = $clog2(NREG),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [RIW-1:0] push_rd,
  input  logic [DW-1:0]  push_val,
  input  logic           push_tnt,
  input  logic           push_kill,
  input  logic           pop_req,
  output logic           full,
  output logic           empty,
  output logic           wr_en,
  output logic [RIW-1:0] wr_rd,
  output logic [DW-1:0]  wr_val,
  output logic           wr_tnt,
  input  logic [RIW-1:0] q1_rs,
  output logic           q1_hit,
  output logic [DW-1:0]  q1_val,
  output logic           q1_tnt,
  input  logic [RIW-1:0] q2_rs,
  output logic           q2_hit,
  output logic [DW-1:0]  q2_val,
  output logic           q2_tnt
);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [DW-1:0]  ent_val [DEPTH];
  logic           ent_tnt [DEPTH];
  logic [RIW-1:0] ent_rd  [DEPTH];
  logic           ent_kill[DEPTH];

  logic [PW-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [PW:0]   cnt_q, cnt_d;
  logic          pop_do;

  assign full   = (cnt_q == FULL_CNT);
  assign empty  = (cnt_q == '0);
  assign pop_do = pop_req && !empty;

  assign wr_en  = pop_do && !ent_kill[rd_ptr_q];
  assign wr_rd  = ent_rd[rd_ptr_q];
  assign wr_val = ent_val[rd_ptr_q];
  assign wr_tnt = ent_tnt[rd_ptr_q];

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (pop_do) rd_ptr_d = rd_ptr_q + 1'b1;
    if (push)   wr_ptr_d = wr_ptr_q + 1'b1;
    if (push && !pop_do)      cnt_d = cnt_q + 1'b1;
    else if (pop_do && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ent_val[wr_ptr_q]  <= push_val;
      ent_tnt[wr_ptr_q]  <= push_tnt;
      ent_rd[wr_ptr_q]   <= push_rd;
      ent_kill[wr_ptr_q] <= push_kill;
    end
  end

  // Walk oldest to youngest so that the last live match wins.
  always_comb begin
    logic [PW-1:0] idx;
    q1_hit = 1'b0; q1_val = '0; q1_tnt = 1'b0;
    q2_hit = 1'b0; q2_val = '0; q2_tnt = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = rd_ptr_q + PW'(i);
      if (((PW+1)'(i) < cnt_q) && !ent_kill[idx]) begin
        if (ent_rd[idx] == q1_rs) begin
          q1_hit = 1'b1; q1_val = ent_val[idx]; q1_tnt = ent_tnt[idx];
        end
        if (ent_rd[idx] == q2_rs) begin
          q2_hit = 1'b1; q2_val = ent_val[idx]; q2_tnt = ent_tnt[idx];
        end
      end
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_do) |-> !push);
  assert_empty_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push) |=> empty);
endmodule

// File: rtl/taint_core.sv
module taint_core
  import taint_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DW     = 5,
  parameter int DEPTH  = 4,
  parameter int WIN_LO = 4,
  parameter int WIN_HI = 23,
  localparam int RIW   = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  output logic           instr_ready,
  input  logic [1:0]     instr_op,
  input  logic [RIW-1:0] instr_rd,
  input  logic [RIW-1:0] instr_rs1,
  input  logic [RIW-1:0] instr_rs2,
  input  logic [DW-1:0]  instr_imm,
  input  logic           instr_mispred,
  input  logic           retire,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           mem_wtaint,
  input  logic [DW-1:0]  mem_rdata,
  output logic           violation
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ni   <= rst_s1_q;
    end
  end

  op_e           op;
  logic          full, empty_unused, fire, push;
  logic          wr_en, wr_tnt;
  logic [RIW-1:0] wr_rd;
  logic [DW-1:0] wr_val;
  logic [DW-1:0] rf1_v, rf2_v, fq1_v, fq2_v, a_v, b_v, res_v, addr;
  logic          rf1_t, rf2_t, fq1_t, fq2_t, fq1_h, fq2_h, a_t, b_t;
  logic          res_t, addr_t, mem_acc, writes;
  logic          viol_q, viol_d;

  assign op          = op_e'(instr_op);
  assign instr_ready = !full;
  assign fire        = instr_valid && instr_ready;
  assign push        = fire && writes;

  tc_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_ni),
    .we(wr_en), .wa(wr_rd), .wd(wr_val), .wt(wr_tnt),
    .ra1(instr_rs1), .ra2(instr_rs2),
    .rd1(rf1_v), .rt1(rf1_t), .rd2(rf2_v), .rt2(rf2_t)
  );

  tc_resq #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_ni),
    .push(push), .push_rd(instr_rd), .push_val(res_v), .push_tnt(res_t),
    .push_kill(instr_mispred), .pop_req(retire),
    .full(full), .empty(empty_unused),
    .wr_en(wr_en), .wr_rd(wr_rd), .wr_val(wr_val), .wr_tnt(wr_tnt),
    .q1_rs(instr_rs1), .q1_hit(fq1_h), .q1_val(fq1_v), .q1_tnt(fq1_t),
    .q2_rs(instr_rs2), .q2_hit(fq2_h), .q2_val(fq2_v), .q2_tnt(fq2_t)
  );

  assign a_v = fq1_h ? fq1_v : rf1_v;
  assign a_t = fq1_h ? fq1_t : rf1_t;
  assign b_v = fq2_h ? fq2_v : rf2_v;
  assign b_t = fq2_h ? fq2_t : rf2_t;

  tc_exec #(.DW(DW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_ex (
    .op(op), .a_val(a_v), .a_tnt(a_t), .b_val(b_v), .b_tnt(b_t),
    .imm(instr_imm), .rdata(mem_rdata),
    .res_val(res_v), .res_tnt(res_t), .addr(addr), .addr_tnt(addr_t),
    .mem_acc(mem_acc), .writes(writes)
  );

  assign mem_req    = fire && mem_acc;
  assign mem_we     = fire && (op == OP_STORE);
  assign mem_addr   = addr;
  assign mem_wdata  = b_v;
  assign mem_wtaint = b_t;

  assign viol_d = viol_q || (mem_req && addr_t);
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= viol_d;
  end
  assign violation = viol_q;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    violation |=> violation);
  assert_flag_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && addr_t) |=> violation);
  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    !instr_ready |-> !mem_req);
  assert_req_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |-> instr_valid);
endmodule

// File: tb/taint_core_tb.sv
`timescale 1ns/1ps
module taint_core_tb;
  localparam logic [1:0] A = 2'd0, L = 2'd1, S = 2'd2, B = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] rd, rs1, rs2;
    logic [4:0] imm;
    logic       misp;
    logic [4:0] rdata;
    logic [4:0] ewd;
    logic       ewt;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{L,3'd1,3'd0,3'd0,5'd5 ,1'b0,5'd7 ,5'd0 ,1'b0}, // R3 in window
    '{L,3'd2,3'd0,3'd0,5'd3 ,1'b0,5'd9 ,5'd0 ,1'b0}, // R3 below window
    '{S,3'd0,3'd0,3'd1,5'd0 ,1'b0,5'd0 ,5'd7 ,1'b0}, // R3 clean
    '{S,3'd0,3'd0,3'd2,5'd0 ,1'b0,5'd0 ,5'd9 ,1'b1}, // R3 tainted
    '{L,3'd3,3'd0,3'd0,5'd4 ,1'b0,5'd2 ,5'd0 ,1'b0}, // R3 low bound
    '{L,3'd4,3'd0,3'd0,5'd23,1'b0,5'd30,5'd0 ,1'b0}, // R3 high bound
    '{L,3'd5,3'd0,3'd0,5'd24,1'b0,5'd1 ,5'd0 ,1'b0}, // R3 above window
    '{S,3'd0,3'd0,3'd3,5'd0 ,1'b0,5'd0 ,5'd2 ,1'b0},
    '{S,3'd0,3'd0,3'd4,5'd0 ,1'b0,5'd0 ,5'd30,1'b0},
    '{S,3'd0,3'd0,3'd5,5'd0 ,1'b0,5'd0 ,5'd1 ,1'b1},
    '{A,3'd6,3'd1,3'd4,5'd0 ,1'b0,5'd0 ,5'd0 ,1'b0}, // R2 wrap 7+30
    '{S,3'd0,3'd0,3'd6,5'd0 ,1'b0,5'd0 ,5'd5 ,1'b0}, // R2 R6 forwarded
    '{A,3'd7,3'd1,3'd2,5'd0 ,1'b0,5'd0 ,5'd0 ,1'b0}, // R2 taint OR
    '{S,3'd0,3'd0,3'd7,5'd0 ,1'b0,5'd0 ,5'd16,1'b1},
    '{A,3'd1,3'd2,3'd2,5'd0 ,1'b1,5'd0 ,5'd0 ,1'b0}, // R7 aborted add
    '{S,3'd0,3'd0,3'd1,5'd0 ,1'b0,5'd0 ,5'd7 ,1'b0},
    '{L,3'd3,3'd0,3'd0,5'd30,1'b1,5'd11,5'd0 ,1'b0}, // R7 aborted load
    '{S,3'd0,3'd0,3'd3,5'd0 ,1'b0,5'd0 ,5'd2 ,1'b0},
    '{B,3'd4,3'd2,3'd5,5'd0 ,1'b0,5'd0 ,5'd0 ,1'b0}, // R8 branch no write
    '{S,3'd0,3'd0,3'd4,5'd0 ,1'b0,5'd0 ,5'd30,1'b0},
    '{A,3'd5,3'd5,3'd5,5'd0 ,1'b0,5'd0 ,5'd0 ,1'b0}, // R2 1+1 tainted
    '{S,3'd0,3'd0,3'd5,5'd0 ,1'b0,5'd0 ,5'd2 ,1'b1},
    '{S,3'd0,3'd0,3'd5,5'd9 ,1'b0,5'd0 ,5'd2 ,1'b1}  // R8 address = imm
  };

  logic       clk, rst_n;
  logic       instr_valid, instr_ready, instr_mispred, retire;
  logic [1:0] instr_op;
  logic [2:0] instr_rd, instr_rs1, instr_rs2;
  logic [4:0] instr_imm, mem_addr, mem_wdata, mem_rdata;
  logic       mem_req, mem_we, mem_wtaint, violation;

  int n_chk = 0;
  int n_bad = 0;

  taint_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_rd(instr_rd), .instr_rs1(instr_rs1),
    .instr_rs2(instr_rs2), .instr_imm(instr_imm), .instr_mispred(instr_mispred),
    .retire(retire),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wtaint(mem_wtaint), .mem_rdata(mem_rdata),
    .violation(violation)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at negedge, leave 2 ns to settle, caller samples, then edge.
  task automatic drive(logic v, logic [1:0] op, logic [2:0] rd, logic [2:0] rs1,
                       logic [2:0] rs2, logic [4:0] imm, logic misp,
                       logic [4:0] rdata, logic ret);
    @(negedge clk);
    instr_valid = v; instr_op = op; instr_rd = rd; instr_rs1 = rs1;
    instr_rs2 = rs2; instr_imm = imm; instr_mispred = misp;
    mem_rdata = rdata; retire = ret;
    #2;
  endtask

  task automatic idle(logic ret);
    drive(1'b0, A, 3'd0, 3'd0, 3'd0, 5'd0, 1'b0, 5'd0, ret);
    @(posedge clk);
  endtask

  task automatic observe(string req, logic [2:0] rs, logic [4:0] ewd, logic ewt);
    drive(1'b1, S, 3'd0, 3'd0, rs, 5'd0, 1'b0, 5'd0, 1'b0);
    check(req, {mem_wtaint, mem_wdata}, {ewt, ewd});
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    instr_valid = 1'b0; instr_op = A; instr_rd = '0; instr_rs1 = '0;
    instr_rs2 = '0; instr_imm = '0; instr_mispred = 1'b0; mem_rdata = '0;
    retire = 1'b0;
    do_reset();

    // R1 reset state
    @(negedge clk); #2;
    check("R1 ready", instr_ready, 1);
    check("R1 violation", violation, 0);
    observe("R1 r1 zero", 3'd1, 5'd0, 1'b0);
    observe("R1 r7 zero", 3'd7, 5'd0, 1'b0);

    // Table walk, retire held high so at most one result is pending.
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VT[i].op, VT[i].rd, VT[i].rs1, VT[i].rs2, VT[i].imm,
            VT[i].misp, VT[i].rdata, 1'b1);
      check($sformatf("R10 mem_req row %0d", i), mem_req,
            (VT[i].op == L) || (VT[i].op == S));
      if (VT[i].op == S)
        check($sformatf("R8 store row %0d", i),
              {mem_we, mem_addr, mem_wtaint, mem_wdata},
              {1'b1, VT[i].imm, VT[i].ewt, VT[i].ewd});
      @(posedge clk);
    end
    idle(1'b1);
    @(negedge clk); #2;
    check("R9 clean accesses keep flag low", violation, 0);

    // R6 youngest pending entry wins; retire held low.
    drive(1'b1, A, 3'd6, 3'd1, 3'd1, 5'd0, 1'b0, 5'd0, 1'b0); @(posedge clk);
    drive(1'b1, A, 3'd6, 3'd3, 3'd3, 5'd0, 1'b0, 5'd0, 1'b0); @(posedge clk);
    observe("R6 youngest", 3'd6, 5'd4, 1'b0);

    // R4 fill to DEPTH, then stall.
    drive(1'b1, A, 3'd7, 3'd1, 3'd3, 5'd0, 1'b0, 5'd0, 1'b0); @(posedge clk);
    drive(1'b1, A, 3'd1, 3'd4, 3'd4, 5'd0, 1'b0, 5'd0, 1'b0); @(posedge clk);
    drive(1'b1, L, 3'd5, 3'd0, 3'd0, 5'd5, 1'b0, 5'd17, 1'b0);
    check("R4 ready low when full", instr_ready, 0);
    check("R4 no mem access when stalled", mem_req, 0);
    @(posedge clk);
    idle(1'b1);
    @(negedge clk); #2;
    check("R4 retire frees slot", instr_ready, 1);
    observe("R4 forward after stall", 3'd1, 5'd28, 1'b0);
    repeat (3) idle(1'b1);
    repeat (3) idle(1'b1); // R5 retire on empty
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, A, 3'd7, 3'd1, 3'd3, 5'd0, 1'b0, 5'd0, 1'b0);
      check("R5 still accepting", instr_ready, 1);
      @(posedge clk);
    end
    @(negedge clk); #2;
    check("R5 full after exactly DEPTH", instr_ready, 0);
    repeat (4) idle(1'b1);
    observe("R4 stalled load not executed", 3'd5, 5'd2, 1'b1);
    observe("R2 r7 after drain", 3'd7, 5'd30, 1'b0);

    // R9 monitor
    drive(1'b1, A, 3'd7, 3'd2, 3'd2, 5'd0, 1'b0, 5'd0, 1'b1); @(posedge clk);
    @(negedge clk); #2;
    check("R9 tainted add does not flag", violation, 0);
    drive(1'b1, L, 3'd6, 3'd2, 3'd0, 5'd0, 1'b1, 5'd3, 1'b1); @(posedge clk);
    @(negedge clk); #2;
    check("R9 mispredicted tainted load flags", violation, 1);
    repeat (3) idle(1'b1);
    @(negedge clk); #2;
    check("R9 sticky", violation, 1);
    do_reset();
    @(negedge clk); #2;
    check("R1 violation cleared by reset", violation, 0);
    observe("R1 r2 cleared", 3'd2, 5'd0, 1'b0);

    summary();
  end
endmodule